// File: doc/BRIEF.md
# Bidirectional GPIO Port with External-Bus Override

This block is one eight-bit general-purpose I/O port. Two registers sit behind a small synchronous register bus. One register holds the output levels and the other holds the per-pin direction. Each pin has three signals: an output enable, an output value and an input value. The input value passes through a two-stage synchronizer before any read can see it.

A two-bit mode input chooses how the port is used.

- **Single-chip mode:** the pins work as plain GPIO, and the direction bits decide which pins drive.
- **Expanded mode and emulation mode:** the port carries the upper byte of an external data bus. Port bit i sits on external data line 8+i. Every pin is forced to drive the external bus write data, and the programmed direction bits are left as they are.
- **Emulation mode only:** a read of the data register returns what is seen on the external bus. A write to the data register also goes out on the external bus as a one-cycle strobe.

The register bus has no handshake. A write is taken on the rising clock edge where the write enable is high. A read is combinational from the current address and is never stalled. The external-bus write strobe is a plain pulse with no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and after it is released, both registers are zero. Every pin has its output enable low in single-chip mode, and reading either offset returns 0.
- R2: Offset 0 is the data register and offset 1 is the direction register. A register is loaded from the write data on the rising edge where the write enable is high, and it can be written and read back in any mode.
- R3: In single-chip mode, pin_oe equals the direction register and pin_out equals the data register. A direction bit of 1 drives the pin and a 0 leaves it as a high-impedance input.
- R4: Outside emulation mode, bit i of a read at offset 0 is the data register bit when direction bit i is 1. Otherwise it is the synchronized pin level.
- R5: A pin level change is not visible to a read after one rising edge, and it is visible after two.
- R6: In expanded mode (mode 2'b01) and emulation mode (mode 2'b10), pin_oe is all ones whatever the direction bits hold.
- R7: While the override is active, pin_out equals xbus_out, with bit i carrying external data line 8+i.
- R8: The override never alters the direction register. It reads back unchanged at offset 1, and pin_oe returns to it once single-chip mode is restored.
- R9: In emulation mode, a read at offset 0 returns xbus_in.
- R10: In emulation mode, a write at offset 0 raises xbus_wr_stb in the same cycle with xbus_wr_data equal to the write data, and it also loads the data register. Outside emulation mode, xbus_wr_stb stays low.
- R11: Mode 2'b11 behaves exactly like single-chip mode (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00/11 single-chip, 01 expanded, 10 emulation |
| reg_addr | input | 1 | Register offset: 0 data, 1 direction |
| reg_we | input | 1 | Write enable, taken on the rising edge |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| xbus_out | input | 8 | External bus data to drive on the pins during override |
| xbus_in | input | 8 | Data seen on the external bus, read in emulation |
| xbus_wr_stb | output | 1 | Pulse: data register write mirrored to the external bus |
| xbus_wr_data | output | 8 | Data accompanying xbus_wr_stb |

## Verification
The hardest condition to create is one where the programmed direction bits and the forced bus drive disagree. Checking this means showing that the override does not disturb the direction register, even though the pins never reveal that register while the override is active. The bench programs each direction pattern in single-chip mode and then switches to expanded and emulation modes. It reads offset 1 back through the register bus during the override, and it confirms that pin_oe falls back to the stored pattern after leaving. The emulation write mirror is checked the same way. A value written at offset 0 during emulation is checked for the same-cycle strobe, and it is read back later in single-chip mode with all pins set as outputs.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_EXPAND  = 2'b01,
    MODE_EMULATE = 2'b10,
    MODE_ALT_SC  = 2'b11
  } port_mode_e;

  localparam logic OFFS_DATA = 1'b0;
  localparam logic OFFS_DIR  = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  logic [WIDTH-1:0] wr_value,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= '0;
    else if (wr_data_en) data_q <= wr_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= '0;
    else if (wr_dir_en) dir_q <= wr_value;
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             override,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] bus_drive,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      pad_oe[i]  = override ? 1'b1 : dir_q[i];
      pad_out[i] = override ? bus_drive[i] : data_q[i];
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel_dir,
  input  logic             from_bus,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] bus_seen,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] gp_view;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gp_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
  end

  always_comb begin
    if (sel_dir)       rdata = dir_q;
    else if (from_bus) rdata = bus_seen;
    else               rdata = gp_view;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             reg_addr,
  input  logic             reg_we,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] xbus_out,
  input  logic [WIDTH-1:0] xbus_in,
  output logic             xbus_wr_stb,
  output logic [WIDTH-1:0] xbus_wr_data
);
  logic             ovr_active;
  logic             emu_active;
  logic             wr_data_en;
  logic             wr_dir_en;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  always_comb begin
    ovr_active = (mode == MODE_EXPAND) || (mode == MODE_EMULATE);
    emu_active = (mode == MODE_EMULATE);
    wr_data_en = reg_we && (reg_addr == OFFS_DATA);
    wr_dir_en  = reg_we && (reg_addr == OFFS_DIR);
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .wr_value   (reg_wdata),
    .data_q     (data_q),
    .dir_q      (dir_q)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .override  (ovr_active),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .bus_drive (xbus_out),
    .pad_out   (pin_out),
    .pad_oe    (pin_oe)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
    .sel_dir  (reg_addr == OFFS_DIR),
    .from_bus (emu_active),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .bus_seen (xbus_in),
    .rdata    (reg_rdata)
  );

  assign xbus_wr_stb  = wr_data_en && emu_active;
  assign xbus_wr_data = reg_wdata;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             reg_addr,
  input logic             reg_we,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] reg_rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] xbus_out,
  input logic [WIDTH-1:0] xbus_in,
  input logic             xbus_wr_stb,
  input logic [WIDTH-1:0] xbus_wr_data
);
  logic is_sc;
  logic is_ovr;
  assign is_sc  = (mode == 2'b00) || (mode == 2'b11);
  assign is_ovr = (mode == 2'b01) || (mode == 2'b10);

  // R1
  reset_pins_input_chk: assert property (@(posedge clk)
    (!rst_n && is_sc) |-> (pin_oe == '0));

  // R6
  override_all_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ovr |-> (pin_oe == {WIDTH{1'b1}}));

  // R7
  override_bus_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ovr |-> (pin_out == xbus_out));

  // R9
  emu_read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && reg_addr == 1'b0) |-> (reg_rdata == xbus_in));

  // R10
  emu_write_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && reg_we && reg_addr == 1'b0) |->
      (xbus_wr_stb && xbus_wr_data == reg_wdata));

  // R10
  no_stb_outside_emu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> !xbus_wr_stb);

  // R3
  dir_write_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 1'b1) |=> (!is_sc || pin_oe == $past(reg_wdata)));

  // R2
  dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 1'b1) |=> (reg_addr != 1'b1 || reg_rdata == $past(reg_wdata)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         reg_addr = 1'b0;
  logic         reg_we = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;
  logic [W-1:0] xbus_out = '0;
  logic [W-1:0] xbus_in = '0;
  logic         xbus_wr_stb;
  logic [W-1:0] xbus_wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .xbus_out(xbus_out), .xbus_in(xbus_in),
    .xbus_wr_stb(xbus_wr_stb), .xbus_wr_data(xbus_wr_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic a, input logic [W-1:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    finish_run();
  end

  initial begin
    logic [W-1:0] ddr, dat, pin, last_emu;
    // R1 during reset
    @(negedge clk);
    chk("R1 oe in reset", pin_oe, '0);
    rd("R1 data in reset", 1'b0, '0);
    rd("R1 dir in reset", 1'b1, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, '0);
    rd("R1 dir after reset", 1'b1, '0);

    // R2 R3 R4: sweep every direction pattern in single-chip mode
    for (int k = 0; k < 256; k++) begin
      ddr = W'(k);
      dat = W'(k) ^ 8'h5A;
      pin = W'((k * 37 + 11) & 8'hFF);
      mode = (k % 2 == 0) ? 2'b00 : 2'b11; // R11 alternate encoding
      pin_in = pin;
      wr(1'b1, ddr);
      wr(1'b0, dat);
      @(negedge clk);
      chk("R3 oe", pin_oe, ddr);
      chk("R3 out", pin_out, dat);
      rd("R2 dir readback", 1'b1, ddr);
      rd("R4 data readback", 1'b0, (ddr & dat) | (~ddr & pin));
    end

    // R5 synchronizer latency
    mode = 2'b00;
    wr(1'b1, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hC3;
    @(negedge clk);
    rd("R5 one edge old", 1'b0, 8'h00);
    @(negedge clk);
    rd("R5 two edges new", 1'b0, 8'hC3);

    // R6 R7 R8 R9: override in expanded and emulation modes
    for (int k = 0; k < 64; k++) begin
      ddr = W'(k * 4 + 1);
      mode = 2'b00;
      wr(1'b1, ddr);
      for (int m = 1; m <= 2; m++) begin
        mode = 2'(m);
        xbus_out = W'((k * 53 + m * 7) & 8'hFF);
        xbus_in  = W'((k * 29 + m * 3) & 8'hFF);
        #1;
        chk("R6 forced oe", pin_oe, 8'hFF);
        chk("R7 bus data on pins", pin_out, xbus_out);
        rd("R8 dir kept", 1'b1, ddr);
        if (m == 2) rd("R9 emu read bus", 1'b0, xbus_in);
        @(negedge clk);
      end
      mode = 2'b00;
      #1;
      chk("R8 oe restored", pin_oe, ddr);
    end

    // R10 emulation write mirror and register load
    mode = 2'b00;
    wr(1'b1, 8'hFF);
    for (int k = 0; k < 16; k++) begin
      last_emu = W'((k * 71 + 5) & 8'hFF);
      mode = 2'b10;
      reg_addr = 1'b0; reg_wdata = last_emu; reg_we = 1'b1;
      #1;
      chk("R10 strobe", {7'b0, xbus_wr_stb}, 8'h01);
      chk("R10 mirror data", xbus_wr_data, last_emu);
      @(negedge clk);
      reg_we = 1'b0;
      mode = 2'b00;
      rd("R10 data loaded", 1'b0, last_emu);
      reg_we = 1'b1; reg_wdata = 8'h3C;
      #1;
      chk("R10 no strobe single-chip", {7'b0, xbus_wr_stb}, 8'h00);
      mode = 2'b01;
      #1;
      chk("R10 no strobe expanded", {7'b0, xbus_wr_stb}, 8'h00);
      @(negedge clk);
      reg_we = 1'b0;
      mode = 2'b00;
      rd("R2 write in expanded", 1'b0, 8'h3C);
    end

    finish_run();
  end
endmodule